// File: doc/BRIEF.md
# Non-Restoring Integer Square Root Engine

This block computes the integer square root of an unsigned radicand of `2*ROOT_W` bits, one root bit per clock. A one-cycle start strobe loads the radicand; the engine then brings down the radicand two bits at a time, most significant pair first, and decides one root bit per step. The partial remainder is never put back after a negative trial. A negative result instead makes the next step an addition of the root so far with the suffix `11`. Once an addition brings the remainder back to zero or above, the engine returns to subtracting the root so far with the suffix `01`.

After the last step, one extra cycle applies a single correction. If the remainder is still negative, `2*root+1` is added to it. The root and a signed remainder are then published, and `done_o` pulses. The results stay on the outputs until the next computation finishes. A start is honoured only while the engine is idle, and the cycle in which `done_o` is high counts as idle.

Top module: `nrsqrt_unit`

## Requirements
- R1: While reset is held low (synchronous, active-low), and on the first cycle after it, `busy_o` and `done_o` are 0 and `root_o` and `rem_o` are 0.
- R2: A `start_i` sampled high at a clock edge while `busy_o` is 0 is accepted. `radicand_i` is captured at that edge, and `busy_o` is 1 from the next cycle.
- R3: `done_o` is high for exactly one cycle. It rises `ROOT_W+1` clock edges after the accepting edge, in the same cycle that `busy_o` falls.
- R4: `root_o` equals floor(sqrt(radicand)) for every radicand.
- R5: `rem_o` (two's complement, `ROOT_W+2` bits) equals radicand minus root squared and lies in 0..2*root. A negative end remainder is repaired by adding 2*root+1.
- R6: A `start_i` while `busy_o` is 1 is ignored. The running computation keeps its radicand and its timing.
- R7: `root_o` and `rem_o` change only in a cycle where `done_o` is 1, and hold their values otherwise.
- R8: A step whose previous remainder is negative adds (root<<2)|3; otherwise it subtracts (root<<2)|1. A radicand of 93 therefore gives root 9 and remainder 12.
- R9: Radicand 0 gives root 0 and remainder 0. Radicand 2^(2*ROOT_W)-1 gives root 2^ROOT_W-1 and remainder 2^(ROOT_W+1)-2.
- R10: A start in the cycle where `done_o` is 1 is accepted, and the new result follows after the normal latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a computation |
| radicand_i | input | 2*ROOT_W | Unsigned radicand, sampled on an accepted start |
| busy_o | output | 1 | Engine is computing |
| done_o | output | 1 | One-cycle pulse: a new result is on the outputs |
| root_o | output | ROOT_W | Integer square root |
| rem_o | output | ROOT_W+2 | Signed remainder, radicand minus root squared |

## Verification
Two functions can fall in the same cycle: publishing a result with `done_o`, and accepting a new start. The bench provokes this by issuing computations back to back. The driver waits only for `busy_o` to drop, so each new start is driven in the very cycle `done_o` is high. The monitor then requires three things: the previous result is intact in that cycle, it stays unchanged while the next run proceeds, and the next result arrives exactly `ROOT_W+1` edges after its own accepting edge. A start pulsed in the middle of a run must leave both the value and the timing of that run untouched.

// File: rtl/nrsqrt_pkg.sv
// Package: shared types for the non-restoring square root engine.
// Assumes nothing beyond a single clock domain.
package nrsqrt_pkg;

    // Sequencer phases: waiting, iterating, final correction.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } nr_state_e;

endpackage

// File: rtl/nrsqrt_step.sv
// Module: one non-restoring iteration, purely combinational.
// Brings down a two-bit radicand group and adds or subtracts a trial value,
// chosen by the sign of the incoming remainder, then appends one root bit.
// Assumes REM_W = ROOT_W + 4, which leaves headroom for the remainder bound.
module nrsqrt_step #(
    parameter int ROOT_W = 8,
    parameter int REM_W  = ROOT_W + 4
) (
    input  logic signed [REM_W-1:0]  rem_i,
    input  logic        [ROOT_W-1:0] q_i,
    input  logic        [1:0]        pair_i,
    output logic signed [REM_W-1:0]  rem_o,
    output logic        [ROOT_W-1:0] q_o
);
    localparam int PAD_W = REM_W - ROOT_W - 2;

    logic               neg_prev;
    logic [REM_W-1:0]   shifted;
    logic [REM_W-1:0]   trial;
    logic [REM_W-1:0]   sum;

    // Shift in the radicand pair, pick add or subtract mode, and decide the bit.
    always_comb begin
        neg_prev = rem_i[REM_W-1];
        shifted  = (rem_i <<< 2) | {{(REM_W-2){1'b0}}, pair_i};
        trial    = {{PAD_W{1'b0}}, q_i, (neg_prev ? 2'b11 : 2'b01)};
        sum      = neg_prev ? (shifted + trial) : (shifted - trial);
        rem_o    = sum;
        q_o      = {q_i[ROOT_W-2:0], ~sum[REM_W-1]};
    end
endmodule

// File: rtl/nrsqrt_fix.sv
// Module: end-of-run remainder correction, purely combinational.
// A negative remainder gets 2*root+1 added back; a non-negative one passes.
// Assumes the true remainder fits in ROOT_W+2 signed bits (0..2*root).
module nrsqrt_fix #(
    parameter int ROOT_W = 8,
    parameter int OUT_W  = ROOT_W + 2
) (
    input  logic              rem_neg_i,
    input  logic [OUT_W-1:0]  rem_low_i,
    input  logic [ROOT_W-1:0] q_i,
    output logic [OUT_W-1:0]  rem_o
);
    logic [OUT_W-1:0] corr;

    // Form 2*root+1 and apply it only when the remainder came out negative.
    always_comb begin
        corr  = {1'b0, q_i, 1'b1};
        rem_o = rem_neg_i ? (rem_low_i + corr) : rem_low_i;
    end
endmodule

// File: rtl/nrsqrt_ctrl.sv
// Module: sequencer for the square root engine.
// Accepts a start only when idle, runs ROOT_W steps, then one fix cycle.
// Assumes start_i is synchronous to clk; starts during a run are dropped.
module nrsqrt_ctrl
    import nrsqrt_pkg::*;
#(
    parameter int ROOT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic accept_o,
    output logic step_o,
    output logic fix_o,
    output logic busy_o
);
    localparam int CNT_W = (ROOT_W > 1) ? $clog2(ROOT_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROOT_W - 1);

    nr_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;

    // Decode the phase into strobes for the datapath.
    always_comb begin
        accept_o = start_i && (state_q == ST_IDLE);
        step_o   = (state_q == ST_RUN);
        fix_o    = (state_q == ST_FIX);
        busy_o   = (state_q != ST_IDLE);
    end

    // Advance the phase and count the remaining steps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (start_i) begin
                    state_q <= ST_RUN;
                    cnt_q   <= CNT_LAST;
                end
                ST_RUN: begin
                    if (cnt_q == '0) state_q <= ST_FIX;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted start always leads to a busy engine.
    p_busy_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o);

    // R3: the run phase does not end before the step count is used up.
    p_run_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cnt_q != '0) |=> step_o);

    // R3: the fix phase lasts a single cycle.
    p_fix_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fix_o |=> !busy_o);

    // R6: a start during the run does not disturb the step count.
    p_ignore_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && cnt_q != '0 && start_i) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nrsqrt_unit.sv
// Module: top of the iterative non-restoring integer square root engine.
// Takes a 2*ROOT_W-bit unsigned radicand and returns the root and a signed
// remainder after ROOT_W+1 cycles. Results hold until the next one is ready.
// Assumes ROOT_W >= 2 and a synchronous active-low reset.
module nrsqrt_unit #(
    parameter int ROOT_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [2*ROOT_W-1:0]      radicand_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [ROOT_W-1:0]        root_o,
    output logic signed [ROOT_W+1:0] rem_o
);
    localparam int RAD_W = 2 * ROOT_W;
    localparam int REM_W = ROOT_W + 4;
    localparam int OUT_W = ROOT_W + 2;

    logic                     accept, step, fix;
    logic [RAD_W-1:0]         rad_sh_q;
    logic signed [REM_W-1:0]  work_rem_q, step_rem;
    logic [ROOT_W-1:0]        work_q_q, step_q;
    logic [OUT_W-1:0]         fix_rem;
    logic [ROOT_W-1:0]        root_q;
    logic [OUT_W-1:0]         rem_q;
    logic                     done_q;
    logic                     armed_q;

    nrsqrt_ctrl #(.ROOT_W(ROOT_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .accept_o (accept),
        .step_o   (step),
        .fix_o    (fix),
        .busy_o   (busy_o)
    );

    nrsqrt_step #(.ROOT_W(ROOT_W), .REM_W(REM_W)) step_i (
        .rem_i  (work_rem_q),
        .q_i    (work_q_q),
        .pair_i (rad_sh_q[RAD_W-1 -: 2]),
        .rem_o  (step_rem),
        .q_o    (step_q)
    );

    nrsqrt_fix #(.ROOT_W(ROOT_W), .OUT_W(OUT_W)) fix_i (
        .rem_neg_i (work_rem_q[REM_W-1]),
        .rem_low_i (work_rem_q[OUT_W-1:0]),
        .q_i       (work_q_q),
        .rem_o     (fix_rem)
    );

    // Working registers: load on accept, iterate while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rad_sh_q   <= '0;
            work_rem_q <= '0;
            work_q_q   <= '0;
        end else if (accept) begin
            rad_sh_q   <= radicand_i;
            work_rem_q <= '0;
            work_q_q   <= '0;
        end else if (step) begin
            rad_sh_q   <= rad_sh_q << 2;
            work_rem_q <= step_rem;
            work_q_q   <= step_q;
        end
    end

    // Result registers: publish the corrected result and pulse done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q <= '0;
            rem_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= fix;
            if (fix) begin
                root_q <= work_q_q;
                rem_q  <= fix_rem;
            end
        end
    end

    // Marks that at least one clock has passed since reset, for history checks.
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assign done_o = done_q;
    assign root_o = root_q;
    assign rem_o  = rem_q;

    // R3: done is a single-cycle pulse.
    p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R3: done and busy are never high together.
    p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R5: a published remainder lies in 0..2*root.
    p_rem_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!rem_o[OUT_W-1] && (rem_o <= $signed({1'b0, root_o, 1'b0}))));

    // R7: outside a done cycle the results are unchanged.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !done_o |-> ($stable(root_o) && $stable(rem_o)));
endmodule

// File: tb/nrsqrt_unit_tb_top.sv
// Bench: scoreboard for nrsqrt_unit. The driver queues the expected results;
// the monitor pops and compares them as done pulses appear.
module nrsqrt_unit_tb_top;
    localparam int N = 8;
    localparam int RW = 2 * N;

    typedef struct {
        int rad;
        int root;
        int rem;
        int acc;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [RW-1:0]     rad = '0;
    logic              busy, done;
    logic [N-1:0]      root;
    logic signed [N+1:0] rem;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   have_last = 1'b0;
    int   last_root = 0;
    int   last_rem = 0;
    exp_t sb[$];

    nrsqrt_unit #(.ROOT_W(N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .radicand_i (rad),
        .busy_o     (busy),
        .done_o     (done),
        .root_o     (root),
        .rem_o      (rem)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int isqrt(int x);
        int r = 0;
        while ((r + 1) * (r + 1) <= x) r++;
        return r;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one computation at the first idle negedge; queue its expectation.
    task automatic issue(int value);
        exp_t e;
        while (busy) @(negedge clk);
        e.rad  = value;
        e.root = isqrt(value);
        e.rem  = value - e.root * e.root;
        e.acc  = cyc + 1;
        sb.push_back(e);
        start = 1'b1;
        rad   = RW'(value);
        @(negedge clk);
        start = 1'b0;
        rad   = '0;
        check(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    endtask

    // Monitor: compare results on done, and check holding otherwise.
    always @(negedge clk) begin
        if (rst_n && done) begin
            exp_t e;
            if (sb.size() == 0) begin
                check(1'b0, "R3 unexpected done", 1, 0);
            end else begin
                e = sb.pop_front();
                check(int'(root) == e.root, "R4 root", int'(root), e.root);
                check(int'(rem) == e.rem, "R5 remainder", int'(rem), e.rem);
                check(cyc - e.acc == N + 1, "R3 latency", cyc - e.acc, N + 1);
                check(busy == 1'b0, "R3 busy low with done", int'(busy), 0);
            end
            last_root = int'(root);
            last_rem  = int'(rem);
            have_last = 1'b1;
        end else if (rst_n && have_last) begin
            if (int'(root) != last_root || int'(rem) != last_rem)
                check(1'b0, "R7 hold", int'(root), last_root);
        end
    end

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values while reset is held.
        check(busy == 1'b0 && done == 1'b0, "R1 reset flags", int'(busy), 0);
        check(root == '0 && rem == '0, "R1 reset results", int'(root), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && root == '0, "R1 after reset",
              int'(root), 0);

        // R8: worked example with mixed add and subtract steps.
        issue(93);
        repeat (N + 4) @(negedge clk);
        check(int'(root) == 9 && int'(rem) == 12, "R8 radicand 93", int'(root), 9);

        // R9: edge values.
        issue(0);
        issue(1);
        issue((1 << RW) - 1);
        issue(2);
        repeat (N + 4) @(negedge clk);
        check(int'(root) == 1 && int'(rem) == 1, "R9 radicand 2", int'(root), 1);
        check(sb.size() == 0, "R9 queue drained", sb.size(), 0);

        // R4/R5: perfect squares and their neighbours.
        for (int k = 1; k < (1 << N); k += 37) begin
            issue(k * k);
            issue(k * k - 1);
        end
        issue(255 * 255);

        // R6: a start in the middle of a run is ignored.
        issue(1000);
        repeat (3) @(negedge clk);
        start = 1'b1;
        rad   = RW'(50000);
        @(negedge clk);
        start = 1'b0;
        rad   = '0;
        check(busy == 1'b1, "R6 still busy", int'(busy), 1);
        while (!done) @(negedge clk);
        check(int'(root) == 31 && int'(rem) == 39, "R6 original result kept",
              int'(root), 31);
        @(negedge clk);
        check(busy == 1'b0, "R6 no hidden restart", int'(busy), 0);

        // R10: back-to-back starts land in the done cycle; random values.
        for (int i = 0; i < 60; i++) begin
            issue(int'($urandom_range((1 << RW) - 1, 0)));
        end
        // R7: idle gap with results held.
        repeat (N + 10) @(negedge clk);
        check(done == 1'b0 && busy == 1'b0, "R7 idle after drain", int'(busy), 0);
        check(sb.size() == 0, "R10 all results returned", sb.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule